// File: doc/BRIEF.md
# Seeded Scrambling Code Generator

This block produces the cell-specific complex Gold scrambling code used on a WCDMA downlink, starting at any chip offset inside the 38400-chip code period. A setup command runs the two 18-bit shift registers through one period and records their joint state every `SEED_SPACING` chips in a small seed table. A later generate command does not have to step from chip zero. It reloads the nearest recorded state at or below the requested offset and steps the registers the few remaining chips. It then streams one chip per cycle.

A second generate flavour serves a bank of sixteen correlators. Each output word carries sixteen consecutive chips as parallel lanes: lane j holds the code delayed by j chips, with the in-phase bits in the low half and the quadrature bits in the high half. The window slides one chip per word. A busy flag covers every running command, and commands that arrive while it is set are dropped.

Top module: `scramble_code_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` and `out_valid` are 0 and `out_data` is all zero.
- R2: A setup command (`cmd_op`=0) raises `busy` from the cycle after acceptance. It starts the x register at bit value 1 followed by seventeen zeros and steps x alone `cmd_code` times. It starts y at all ones. It then records a seed at every multiple of `SEED_SPACING` below 38400. `busy` falls `cmd_code` + (38400/`SEED_SPACING` − 1)·`SEED_SPACING` + 2 cycles after the accepting edge.
- R3: A plain generate (`cmd_op`=1) emits, for output k, the in-phase chip of position p = (`cmd_delay`+k) mod 38400 in `out_data` bit 0. All bits other than 0 and 16 are zero. The chip is x(p+n) xor y(p), where x follows x^18+x^7+1, y follows y^18+y^10+y^7+y^5+1, and n is the code number of the last setup.
- R4: The quadrature chip of position p is the same Gold sequence taken 131072 chips later (indices modulo 2^18−1) and appears in `out_data` bit 16.
- R5: In plain mode the first chip appears (`cmd_delay` mod `SEED_SPACING`) + 2 cycles after the accepting edge.
- R6: A packed generate (`cmd_op`=2) emits for output step k a word whose bit j (0..15) is the in-phase chip and bit 16+j the quadrature chip of position (`cmd_delay`+k+j) mod 38400.
- R7: In packed mode the first word appears (`cmd_delay` mod `SEED_SPACING`) + 17 cycles after the accepting edge.
- R8: Exactly `cmd_len` outputs are emitted on consecutive cycles, and `busy` falls in the same cycle as `out_valid`.
- R9: Position 38399 is followed by position 0 of the same code, in both modes.
- R10: A command presented while `busy` is high is ignored, with no effect on the stream in progress or on the stored code.
- R11: `cmd_op`=3, a generate with `cmd_len`=0, and a generate with `cmd_delay` ≥ 38400 are ignored: `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when idle |
| cmd_op | input | 2 | 0 setup, 1 plain generate, 2 packed generate, 3 none |
| cmd_code | input | CODE_W | Code number used by setup |
| cmd_delay | input | DLY_W | Starting chip position |
| cmd_len | input | LEN_W | Number of outputs |
| busy | output | 1 | A command is running |
| out_valid | output | 1 | `out_data` holds an output |
| out_data | output | 2*PACK_W | Chip or packed word, zero when not valid |

## Verification
The hardest case to reach is the period wrap, where the registers must reload seed zero instead of stepping. In packed mode this happens partway through a word, which the bench reaches with offsets a few chips below 38400. The slowest start, one chip below a seed boundary, is also driven, and its latency is counted exactly. The expected chips come from two full-length m-sequence tables that the bench builds from the polynomials, so the quadrature tap set in the design is checked against a plain 131072-chip index shift.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int REG_W = 18;

  typedef struct packed {
    logic [REG_W-1:0] x;
    logic [REG_W-1:0] y;
  } gen_state_t;

  typedef enum logic [1:0] {
    OP_SETUP = 2'd0,
    OP_PLAIN = 2'd1,
    OP_PACK  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  // bit j holds x(i+j); new bit enters at the top
  function automatic logic [REG_W-1:0] x_next(input logic [REG_W-1:0] x);
    return {x[0] ^ x[7], x[REG_W-1:1]};
  endfunction

  function automatic logic [REG_W-1:0] y_next(input logic [REG_W-1:0] y);
    return {y[0] ^ y[5] ^ y[7] ^ y[10], y[REG_W-1:1]};
  endfunction

  function automatic logic chip_re(input gen_state_t s);
    return s.x[0] ^ s.y[0];
  endfunction

  // taps that yield the sequence 131072 chips ahead
  function automatic logic chip_im(input gen_state_t s);
    return s.x[4] ^ s.x[6] ^ s.x[15] ^ s.y[5] ^ s.y[6] ^ (^s.y[15:8]);
  endfunction

  function automatic int slot_of(input int d, input int sp);
    return d / sp;
  endfunction

  function automatic int offset_of(input int d, input int sp);
    return d % sp;
  endfunction

endpackage

// File: rtl/scr_lfsr_pair.sv
module scr_lfsr_pair
  import scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       step_x,
  input  logic       step_y,
  input  logic       load_en,
  input  gen_state_t load_val,
  output gen_state_t cur,
  output logic       chip_i,
  output logic       chip_q
);

  localparam logic [REG_W-1:0] X_START = REG_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur.x <= X_START;
      cur.y <= '1;
    end else if (load_en) begin
      cur <= load_val;
    end else if (start) begin
      cur.x <= X_START;
      cur.y <= '1;
    end else begin
      if (step_x) cur.x <= x_next(cur.x);
      if (step_y) cur.y <= y_next(cur.y);
    end
  end

  assign chip_i = chip_re(cur);
  assign chip_q = chip_im(cur);

  // R2
  x_alive_chk: assert property (@(posedge clk) disable iff (rst) cur.x != '0);
  // R3
  y_alive_chk: assert property (@(posedge clk) disable iff (rst) cur.y != '0);

endmodule

// File: rtl/scr_seed_mem.sv
module scr_seed_mem
  import scr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  gen_state_t    wr_data,
  input  logic [AW-1:0] rd_addr,
  output gen_state_t    rd_data
);

  gen_state_t slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_data;
  end

  assign rd_data = slots[rd_addr];

  // R2
  seed_addr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_addr) < DEPTH));

endmodule

// File: rtl/scr_pack_win.sv
module scr_pack_win #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         in_i,
  input  logic         in_q,
  output logic [W-1:0] word_i,
  output logic [W-1:0] word_q
);

  logic [W-1:0] hist_i, hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_i <= '0;
      hist_q <= '0;
    end else if (shift_en) begin
      hist_i <= {in_i, hist_i[W-1:1]};
      hist_q <= {in_q, hist_q[W-1:1]};
    end
  end

  // oldest chip in lane 0, current chip in the top lane
  assign word_i = {in_i, hist_i[W-1:1]};
  assign word_q = {in_q, hist_q[W-1:1]};

endmodule

// File: rtl/scramble_code_gen.sv
module scramble_code_gen
  import scr_pkg::*;
#(
  parameter int CODE_LEN     = 38400,
  parameter int SEED_SPACING = 2400,
  parameter int CODE_W       = 13,
  parameter int LEN_W        = 16,
  parameter int PACK_W       = 16,
  localparam int DLY_W       = $clog2(CODE_LEN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [CODE_W-1:0]   cmd_code,
  input  logic [DLY_W-1:0]    cmd_delay,
  input  logic [LEN_W-1:0]    cmd_len,
  output logic                busy,
  output logic                out_valid,
  output logic [2*PACK_W-1:0] out_data
);

  localparam int NSEED   = CODE_LEN / SEED_SPACING;
  localparam int SEED_AW = (NSEED > 1) ? $clog2(NSEED) : 1;
  localparam int SP_W    = (SEED_SPACING > 1) ? $clog2(SEED_SPACING) : 1;
  localparam int FILL_W  = $clog2(PACK_W) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_XADV, S_SEED, S_LOAD, S_SKIP, S_FILL, S_OUT
  } st_e;

  st_e                 state;
  logic [CODE_W-1:0]   code_cnt;
  logic [SP_W-1:0]     phase;
  logic [SEED_AW-1:0]  seed_idx;
  logic [SP_W-1:0]     rem;
  logic [LEN_W-1:0]    left;
  logic [FILL_W-1:0]   fill;
  logic [DLY_W-1:0]    pos;
  logic                pack_q;

  // named internal events
  logic cmd_legal, cmd_accept, seed_wr, seed_last, seed_step;
  logic adv, wrap_now, step_x, step_y, load_en, start;
  logic [SEED_AW-1:0] rd_addr;
  gen_state_t cur, rd_seed;
  logic chip_i, chip_q;
  logic [PACK_W-1:0] win_i, win_q;

  assign cmd_legal  = (cmd_op == OP_SETUP) ||
                      ((cmd_op == OP_PLAIN || cmd_op == OP_PACK) &&
                       cmd_len != '0 && 32'(cmd_delay) < CODE_LEN);
  assign cmd_accept = cmd_valid && state == S_IDLE && cmd_legal;
  assign start      = cmd_accept && cmd_op == OP_SETUP;

  assign seed_wr    = state == S_SEED && phase == '0;
  assign seed_last  = seed_wr && 32'(seed_idx) == NSEED - 1;
  assign seed_step  = state == S_SEED && !seed_last;

  assign adv        = (state == S_SKIP && rem != '0) || state == S_FILL || state == S_OUT;
  assign wrap_now   = adv && 32'(pos) == CODE_LEN - 1;

  assign step_x  = (state == S_XADV && code_cnt != '0) || seed_step || (adv && !wrap_now);
  assign step_y  = seed_step || (adv && !wrap_now);
  assign load_en = state == S_LOAD || wrap_now;
  assign rd_addr = (state == S_LOAD) ? seed_idx : '0;

  scr_lfsr_pair u_regs (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .step_x   (step_x),
    .step_y   (step_y),
    .load_en  (load_en),
    .load_val (rd_seed),
    .cur      (cur),
    .chip_i   (chip_i),
    .chip_q   (chip_q)
  );

  scr_seed_mem #(.DEPTH(NSEED)) u_seeds (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (seed_wr),
    .wr_addr (seed_idx),
    .wr_data (cur),
    .rd_addr (rd_addr),
    .rd_data (rd_seed)
  );

  scr_pack_win #(.W(PACK_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (state == S_FILL || (state == S_OUT && pack_q)),
    .in_i     (chip_i),
    .in_q     (chip_q),
    .word_i   (win_i),
    .word_q   (win_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      code_cnt <= '0;
      phase    <= '0;
      seed_idx <= '0;
      rem      <= '0;
      left     <= '0;
      fill     <= '0;
      pack_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmd_accept) begin
          if (cmd_op == OP_SETUP) begin
            code_cnt <= cmd_code;
            state    <= S_XADV;
          end else begin
            seed_idx <= SEED_AW'(slot_of(32'(cmd_delay), SEED_SPACING));
            rem      <= SP_W'(offset_of(32'(cmd_delay), SEED_SPACING));
            left     <= cmd_len;
            pack_q   <= cmd_op == OP_PACK;
            state    <= S_LOAD;
          end
        end
        S_XADV: begin
          if (code_cnt != '0) code_cnt <= code_cnt - CODE_W'(1);
          else begin
            phase    <= '0;
            seed_idx <= '0;
            state    <= S_SEED;
          end
        end
        S_SEED: begin
          if (seed_last) state <= S_IDLE;
          else begin
            phase <= (32'(phase) == SEED_SPACING - 1) ? '0 : phase + SP_W'(1);
            if (seed_wr) seed_idx <= seed_idx + SEED_AW'(1);
          end
        end
        S_LOAD: state <= S_SKIP;
        S_SKIP: begin
          if (rem != '0) rem <= rem - SP_W'(1);
          else if (pack_q) begin
            fill  <= FILL_W'(PACK_W - 1);
            state <= S_FILL;
          end else state <= S_OUT;
        end
        S_FILL: begin
          fill <= fill - FILL_W'(1);
          if (fill == FILL_W'(1)) state <= S_OUT;
        end
        S_OUT: begin
          left <= left - LEN_W'(1);
          if (left == LEN_W'(1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else if (state == S_LOAD) pos <= DLY_W'(32'(seed_idx) * SEED_SPACING);
    else if (adv) pos <= wrap_now ? '0 : pos + DLY_W'(1);
  end

  assign busy      = state != S_IDLE;
  assign out_valid = state == S_OUT;

  always_comb begin
    out_data = '0;
    if (out_valid) begin
      if (pack_q) out_data = {win_q, win_i};
      else begin
        out_data[0]      = chip_i;
        out_data[PACK_W] = chip_q;
      end
    end
  end

  // R9
  pos_range_chk: assert property (@(posedge clk) disable iff (rst) 32'(pos) < CODE_LEN);
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(pack_q));
  // R8
  stream_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> !busy);
  // R11
  idle_op_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'd3) |=> !busy);

endmodule

// File: tb/test_scramble_code_gen.sv
module test_scramble_code_gen;

  localparam int CL = 38400;
  localparam int SP = 2400;
  localparam int NS = CL / SP;
  localparam int P  = 262143;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd3;
  logic [12:0] cmd_code = '0;
  logic [15:0] cmd_delay = '0;
  logic [15:0] cmd_len = '0;
  logic        busy, out_valid;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  scramble_code_gen i_scramble_code_gen (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_code(cmd_code), .cmd_delay(cmd_delay), .cmd_len(cmd_len),
    .busy(busy), .out_valid(out_valid), .out_data(out_data)
  );

  // op, delay, length
  localparam logic [33:0] VEC [8] = '{
    {2'd1, 16'd0,     16'd40},
    {2'd1, 16'd2401,  16'd20},
    {2'd1, 16'd7199,  16'd5},
    {2'd2, 16'd300,   16'd10},
    {2'd2, 16'd38390, 16'd12},
    {2'd1, 16'd38395, 16'd10},
    {2'd2, 16'd4800,  16'd20},
    {2'd1, 16'd36000, 16'd3}
  };

  bit xs [P];
  bit ys [P];
  int code_now = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  function automatic bit ci(int p);
    return xs[(p + code_now) % P] ^ ys[p];
  endfunction

  function automatic bit cq(int p);
    int s = (p + 131072) % P;
    return xs[(s + code_now) % P] ^ ys[s];
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic send(int op, int code, int delay, int len);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_code  = 13'(code);
    cmd_delay = 16'(delay);
    cmd_len   = 16'(len);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic run_setup(int code);
    int lat = 1;
    send(0, code, 0, 0);
    @(negedge clk);
    check(busy == 1'b1, "R2", "busy after setup", 32'(busy), 32'd1);
    while (busy && lat < 60000) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    check(lat == code + 3 + (NS - 1) * SP, "R2", "setup duration", 32'(lat),
          32'(code + 3 + (NS - 1) * SP));
    code_now = code;
  endtask

  task automatic run_gen(int op, int delay, int len, bit poke);
    int lat = 1;
    int k = 0;
    int exp_lat = delay % SP + ((op == 2) ? 18 : 3);
    bit wraps = (delay + len + ((op == 2) ? 15 : 0)) > CL;
    send(op, 0, delay, len);
    forever begin
      @(negedge clk);
      if (out_valid || lat > 5000) break;
      @(posedge clk); lat++;
    end
    check(lat == exp_lat, (op == 2) ? "R7" : "R5", "start latency", 32'(lat), 32'(exp_lat));
    while (out_valid && k < len + 4) begin
      if (op == 2) begin
        logic [31:0] e = '0;
        for (int j = 0; j < 16; j++) begin
          e[j]      = ci((delay + k + j) % CL);
          e[16 + j] = cq((delay + k + j) % CL);
        end
        check(out_data == e, wraps ? "R9" : "R6", "packed word", out_data, e);
      end else begin
        int p = (delay + k) % CL;
        check(out_data[0] == ci(p), wraps ? "R9" : "R3", "I chip", 32'(out_data[0]), 32'(ci(p)));
        check(out_data[16] == cq(p), wraps ? "R9" : "R4", "Q chip", 32'(out_data[16]), 32'(cq(p)));
        check((out_data & 32'hFFFE_FFFE) == 0, "R3", "unused bits", out_data, 32'd0);
      end
      if (poke && k == 3) begin
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_code = 13'd17;
      end
      if (poke && k == 4) cmd_valid = 1'b0;
      k++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check(k == len, "R8", "output count", 32'(k), 32'(len));
    check(!busy, "R8", "busy at stream end", 32'(busy), 32'd0);
  endtask

  task automatic expect_ignored(int op, int delay, int len);
    send(op, 0, delay, len);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(!busy && !out_valid, "R11", "illegal command ignored", {30'd0, busy, out_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 18; i++) begin
      xs[i] = (i == 0);
      ys[i] = 1'b1;
    end
    for (int i = 0; i + 18 < P; i++) begin
      xs[i + 18] = xs[i + 7] ^ xs[i];
      ys[i + 18] = ys[i + 10] ^ ys[i + 7] ^ ys[i + 5] ^ ys[i];
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !out_valid && out_data == 0, "R1", "in reset",
          out_data | {30'd0, busy, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !out_valid && out_data == 0, "R1", "after reset",
          out_data | {30'd0, busy, out_valid}, 32'd0);

    expect_ignored(3, 0, 5);
    expect_ignored(1, 100, 0);
    expect_ignored(1, CL, 5);

    run_setup(5);

    for (int v = 0; v < 8; v++) begin
      run_gen(int'(VEC[v][33:32]), int'(VEC[v][31:16]), int'(VEC[v][15:0]), 1'b0);
    end

    // R10: setup request in mid-stream must be dropped
    run_gen(1, 1000, 12, 1'b1);
    repeat (2) @(negedge clk);
    check(!busy, "R10", "no setup after poke", 32'(busy), 32'd0);
    run_gen(1, 4801, 6, 1'b0);

    run_setup(17);
    run_gen(2, 12345, 8, 1'b0);
    run_gen(1, 0, 4, 1'b0);

    finish_up();
  end

endmodule